// File: doc/BRIEF.md
# Effective Address Decoder and Bank Window Translator

This unit turns the 21-bit address operand of a load/store instruction into a 16-bit effective address, then maps that address onto a physical memory address. The top five bits of the operand name a base register. When those bits are all ones, the operand holds an absolute address instead. In every other case, bit 15 chooses between two forms. One form adds a second register, named in the low five bits. The other adds a 15-bit immediate. The surrounding pipeline reads the named registers and presents their values on the base and offset inputs in the same cycle as the operand.

The lower half of the 16-bit space passes straight through to built-in memory. The upper half is cut into four 8 KiB windows. Each window is redirected to one of 256 banks through a small table of bank registers. A synchronous write port loads that table. The effective address, the physical address and a banked/internal flag are all registered, so they appear one clock after the inputs.

Top module: `ea_bank_xlate`

## Requirements
- R1: When operand bits [20:16] equal 5'b11111, the effective address is operand bits [15:0]; the base and offset inputs have no effect.
- R2: When bits [20:16] are not all ones and bit 15 is 0, the effective address is base_val + ofs_val modulo 2^16; operand bits [14:5] have no effect.
- R3: When bits [20:16] are not all ones and bit 15 is 1, the effective address is base_val + zero-extended operand bits [14:0], modulo 2^16; ofs_val has no effect.
- R4: An effective address below 16'h8000 gives is_banked = 0 and phys_addr = the effective address zero-extended to 21 bits.
- R5: An effective address at or above 16'h8000 gives is_banked = 1 and phys_addr = {bank[ea[14:13]], ea[12:0]}, where bank[i] is the 8-bit bank register i.
- R6: After reset, bank registers 0, 1, 2 and 3 hold the values 0, 1, 2 and 3.
- R7: A clock edge with bank_we = 1 loads bank_wdata into bank register bank_widx. A translation registered on that same edge still uses the old value, and translations on later edges use the new one. With bank_we = 0, no bank register changes.
- R8: All outputs are registered with one clock of latency. A synchronous active-high reset clears eff_addr, phys_addr and is_banked to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd | input | 21 | Address operand: base code [20:16], mode bit [15], offset/immediate/absolute below |
| base_val | input | 16 | Value of the register named by opnd[20:16] |
| ofs_val | input | 16 | Value of the register named by opnd[4:0] |
| bank_we | input | 1 | Bank register write enable |
| bank_widx | input | 2 | Bank register index to write |
| bank_wdata | input | 8 | Bank number to load |
| eff_addr | output | 16 | Registered effective address |
| phys_addr | output | 21 | Registered physical address |
| is_banked | output | 1 | Registered flag: 1 for a banked window, 0 for built-in memory |

## Verification
A corrupted bank register stays hidden until an address falls in its window. After that, every translation there carries the wrong upper eight bits of phys_addr, one clock after the operand is presented. The bench therefore sweeps all four windows both before and after random bank writes. A wrong mode decode or carry shows up at once on eff_addr. The bench drives operands whose ignored fields vary, along with sums that wrap past 16'hFFFF. A write that lands one edge too early or too late shows up on the next access to the written window, and the bench probes exactly that edge.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    AM_ABS    = 2'd0,
    AM_REGREG = 2'd1,
    AM_REGIMM = 2'd2
  } amode_e;
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RSEL_W = 5,
  localparam int OPND_W = AW + RSEL_W
) (
  input  logic [OPND_W-1:0] opnd,
  output amode_e            amode,
  output logic [AW-1:0]     imm_ext,
  output logic [AW-1:0]     abs_addr
);
  localparam logic [RSEL_W-1:0] ABS_CODE = '1;

  always_comb begin
    abs_addr = opnd[AW-1:0];
    imm_ext  = {1'b0, opnd[AW-2:0]};
    if (opnd[OPND_W-1 -: RSEL_W] == ABS_CODE) amode = AM_ABS;
    else if (opnd[AW-1])                      amode = AM_REGIMM;
    else                                      amode = AM_REGREG;
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  amode_e        amode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] ofs_val,
  input  logic [AW-1:0] imm_ext,
  input  logic [AW-1:0] abs_addr,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] addend;

  always_comb begin
    addend = (amode == AM_REGIMM) ? imm_ext : ofs_val;
    if (amode == AM_ABS) ea = abs_addr;
    else                 ea = base_val + addend;
  end
endmodule

// File: rtl/bank_regs.sv
module bank_regs #(
  parameter int WIN_CNT = 4,
  parameter int BANK_W  = 8,
  localparam int IDX_W  = $clog2(WIN_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BANK_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [BANK_W-1:0] rdata
);
  logic [BANK_W-1:0] regs [WIN_CNT];

  for (genvar i = 0; i < WIN_CNT; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                  regs[i] <= BANK_W'(i);
      else if (we && widx == IDX_W'(i))         regs[i] <= wdata;
    end

    // R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(we && widx == IDX_W'(i))) |-> $stable(regs[i]));
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/ea_bank_xlate.sv
module ea_bank_xlate
  import ea_pkg::*;
#(
  parameter int AW      = 16,
  parameter int RSEL_W  = 5,
  parameter int WIN_CNT = 4,
  parameter int BANK_W  = 8,
  localparam int OPND_W = AW + RSEL_W,
  localparam int IDX_W  = $clog2(WIN_CNT),
  localparam int WOFS_W = AW - 1 - IDX_W,
  localparam int PHYS_W = BANK_W + WOFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPND_W-1:0] opnd,
  input  logic [AW-1:0]     base_val,
  input  logic [AW-1:0]     ofs_val,
  input  logic              bank_we,
  input  logic [IDX_W-1:0]  bank_widx,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [AW-1:0]     eff_addr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              is_banked
);
  amode_e            amode;
  logic [AW-1:0]     imm_ext, abs_addr, ea;
  logic [BANK_W-1:0] bank_sel;
  logic [PHYS_W-1:0] phys_nxt;
  logic              upper;

  ea_mode_decode #(.AW(AW), .RSEL_W(RSEL_W)) u_dec (
    .opnd(opnd), .amode(amode), .imm_ext(imm_ext), .abs_addr(abs_addr)
  );

  ea_adder #(.AW(AW)) u_add (
    .amode(amode), .base_val(base_val), .ofs_val(ofs_val),
    .imm_ext(imm_ext), .abs_addr(abs_addr), .ea(ea)
  );

  bank_regs #(.WIN_CNT(WIN_CNT), .BANK_W(BANK_W)) u_banks (
    .clk(clk), .rst(rst), .we(bank_we), .widx(bank_widx), .wdata(bank_wdata),
    .ridx(ea[AW-2 -: IDX_W]), .rdata(bank_sel)
  );

  always_comb begin
    upper = ea[AW-1];
    if (upper) phys_nxt = {bank_sel, ea[WOFS_W-1:0]};
    else       phys_nxt = PHYS_W'(ea[AW-2:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_addr  <= '0;
      phys_addr <= '0;
      is_banked <= 1'b0;
    end else begin
      eff_addr  <= ea;
      phys_addr <= phys_nxt;
      is_banked <= upper;
    end
  end

  // R1
  abs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opnd[OPND_W-1 -: RSEL_W]) == '1)
      |-> eff_addr == $past(opnd[AW-1:0]));
  // R4
  internal_map_chk: assert property (@(posedge clk) disable iff (rst)
    !is_banked |-> phys_addr == PHYS_W'(eff_addr));
  // R5
  banked_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    is_banked |-> (phys_addr[WOFS_W-1:0] == eff_addr[WOFS_W-1:0] && eff_addr[AW-1]));
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (phys_addr == '0 && eff_addr == '0 && !is_banked));
endmodule

// File: tb/ea_bank_xlate_bench.sv
module ea_bank_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [20:0] opnd = '0;
  logic [15:0] base_val = '0, ofs_val = '0;
  logic        bank_we = 1'b0;
  logic [1:0]  bank_widx = '0;
  logic [7:0]  bank_wdata = '0;
  logic [15:0] eff_addr;
  logic [20:0] phys_addr;
  logic        is_banked;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] bank_m [4];

  always #10 clk = ~clk;

  ea_bank_xlate u_ea_bank_xlate (
    .clk(clk), .rst(rst), .opnd(opnd), .base_val(base_val), .ofs_val(ofs_val),
    .bank_we(bank_we), .bank_widx(bank_widx), .bank_wdata(bank_wdata),
    .eff_addr(eff_addr), .phys_addr(phys_addr), .is_banked(is_banked)
  );

  function automatic logic [15:0] ea_ref(input logic [20:0] op, input logic [15:0] b, input logic [15:0] o);
    if (op[20:16] == 5'h1F) return op[15:0];
    if (op[15])             return b + {1'b0, op[14:0]};
    return b + o;
  endfunction

  function automatic logic [20:0] phys_ref(input logic [15:0] ea);
    if (ea[15]) return {bank_m[ea[14:13]], ea[12:0]};
    return {6'b0, ea[14:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operand (and optional bank write), then check the registered result.
  task automatic xlate(input string req, input logic [20:0] op, input logic [15:0] b,
                       input logic [15:0] o, input logic we, input logic [1:0] wi,
                       input logic [7:0] wd);
    logic [15:0] e_ea;
    @(negedge clk);
    opnd = op; base_val = b; ofs_val = o;
    bank_we = we; bank_widx = wi; bank_wdata = wd;
    e_ea = ea_ref(op, b, o);
    @(posedge clk); #1;
    chk({req, " ea"}, 64'(eff_addr), 64'(e_ea));
    chk({req, " phys"}, 64'(phys_addr), 64'(phys_ref(e_ea)));
    chk({req, " banked"}, 64'(is_banked), 64'(e_ea[15]));
    if (we) bank_m[wi] = wd;
    bank_we = 1'b0;
  endtask

  initial begin
    logic [15:0] ea_a;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) bank_m[i] = 8'(i);
    opnd = 21'h1FFFFF;
    repeat (5) @(posedge clk);
    #1;
    // R8 reset state
    chk("R8 reset ea", 64'(eff_addr), 64'h0);
    chk("R8 reset phys", 64'(phys_addr), 64'h0);
    chk("R8 reset banked", 64'(is_banked), 64'h0);
    @(negedge clk); rst = 1'b0;

    // R6 reset bank values via each window (absolute mode)
    for (int w = 0; w < 4; w++)
      xlate("R6", {5'h1F, 1'b1, 2'(w), 13'h0}, 16'hDEAD, 16'hBEEF, 1'b0, 2'd0, 8'd0);
    // R1 absolute ignores base/ofs; R4 boundary below window
    xlate("R1", {5'h1F, 16'h7FFF}, 16'h1234, 16'h4321, 1'b0, 2'd0, 8'd0);
    xlate("R4", {5'h1F, 16'h0000}, 16'hFFFF, 16'hFFFF, 1'b0, 2'd0, 8'd0);
    // R2 wrap past 16'hFFFF, middle bits ignored
    xlate("R2", {5'd3, 1'b0, 10'h000, 5'd4}, 16'hFFFF, 16'h0001, 1'b0, 2'd0, 8'd0);
    @(negedge clk); opnd = {5'd3, 1'b0, 10'h3FF, 5'd4}; base_val = 16'h8123; ofs_val = 16'h2000;
    @(posedge clk); #1; ea_a = eff_addr;
    @(negedge clk); opnd = {5'd3, 1'b0, 10'h155, 5'd4};
    @(posedge clk); #1;
    chk("R2 ignored middle bits", 64'(eff_addr), 64'(ea_a));
    chk("R2 sum", 64'(eff_addr), 64'h A123);
    // R3 maximum immediate and wrap; ofs ignored
    xlate("R3", {5'd1, 1'b1, 15'h7FFF}, 16'h8001, 16'h5555, 1'b0, 2'd0, 8'd0);
    xlate("R3", {5'd1, 1'b1, 15'h7FFF}, 16'h0001, 16'hAAAA, 1'b0, 2'd0, 8'd0);
    // R7 write timing: write window 2 while accessing it
    xlate("R7 same edge old", {5'h1F, 16'hC000}, 16'h0, 16'h0, 1'b1, 2'd2, 8'hA5);
    xlate("R7 next edge new", {5'h1F, 16'hDFFF}, 16'h0, 16'h0, 1'b0, 2'd0, 8'd0);
    chk("R7 bank2 now A5", 64'(phys_addr[20:13]), 64'hA5);
    // R7 write with enable low ignored
    @(negedge clk); bank_widx = 2'd2; bank_wdata = 8'h11; bank_we = 1'b0;
    @(posedge clk);
    xlate("R7 we low ignored", {5'h1F, 16'hC004}, 16'h0, 16'h0, 1'b0, 2'd0, 8'd0);
    chk("R7 bank2 kept", 64'(phys_addr[20:13]), 64'hA5);
    // R5 top address of window 3
    xlate("R5", {5'h1F, 16'hFFFF}, 16'h0, 16'h0, 1'b0, 2'd0, 8'd0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [20:0] op;
      op = 21'($urandom);
      if (n % 7 == 0) op[20:16] = 5'h1F;
      xlate("R1-3/R5 random", op, 16'($urandom), 16'($urandom),
            ($urandom % 4) == 0, 2'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule